// File: doc/BRIEF.md
# SGMII Lane Power-Up Sequencer

This block brings a single serial PHY lane up in SGMII mode by stepping the PHY's control pins through a fixed order. A one-cycle start pulse samples a speed code, a reference-clock choice and two polarity-invert flags. The sequencer then holds the PHY in reset and keeps the transmitter idle. It applies the line-rate generation code and waits out a settling interval. Next it programs the reference frequency, the data width and the polarity bits. With a 40 MHz reference it asks an external loader to write the full register table. Finally it powers up the PLL, transmitter and receiver, and completes two polled handshakes with the PHY.

For the whole run the lane-mode selector is forced to zero. The value it had when start was sampled is put back at the end, even if the selector input has changed since. Every wait is bounded by a programmable timeout. A timeout marks the run as failed, but the sequence still runs to the end so the selector is always restored. The PHY's status inputs are asynchronous and pass through a synchronizer before the sequencer uses them.

Top module: `lane_bringup_seq`

## Requirements
- R1: After reset every pin output, `tbl_req_o`, `done_o`, `fail_o` and `sel_o` are 0.
- R2: On start, `sel_i` is saved and `sel_o` is driven to 0 until the final step. In the final step `sel_o` takes the saved value, whatever `sel_i` has done in between.
- R3: The first step drives `phy_rst_o`, `tx_idle_o` and `ivref_pu_o` high, with PLL, TX and RX power low. In the next cycle `phy_rst_o` goes low while `tx_idle_o` stays high.
- R4: `speed_i` code 0 (1.25 Gbps) sets both `gen_tx_o` and `gen_rx_o` to 0x6, and code 1 (3.125 Gbps) sets both to 0x8. Codes 2 and 3 end the run with fail: power-up is never raised and the selector is still restored.
- R5: At least `STAB_CYCLES` cycles pass between the generation code appearing and any later configuration output changing.
- R6: `ref_freq_o` is 0x4 when `ref40_i`=1 (40 MHz) and 0x1 when `ref40_i`=0 (25 MHz). `data_w10_o` goes to 1 (10-bit width) in the same step.
- R7: `tbl_req_o` is raised only when the reference is 40 MHz, and is held until `tbl_ack_i` or a timeout. All configuration, including the table load, completes before PLL power-up.
- R8: `tx_inv_o` and `rx_inv_o` are set only when their own flag was 1 at start.
- R9: `pll_pu_o`, `tx_pu_o` and `rx_pu_o` rise together. `tx_idle_o` drops only after both synchronized PLL-ready inputs are high, or after a timeout.
- R10: `rx_init_o` is held high until the synchronized `rx_init_done_i` has been seen low and then high again. A level that stays high is not accepted.
- R11: Each wait (table ack, PLL ready, rx-init done) ends after `timeout_i`+1 cycles without a response. The timeout sets fail and the sequence carries on to the selector restore.
- R12: `done_o` is a one-cycle pulse. `fail_o` is valid with it and holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| speed_i | input | 2 | 0 = 1.25 Gbps, 1 = 3.125 Gbps, other codes invalid |
| ref40_i | input | 1 | 1 = 40 MHz reference, 0 = 25 MHz |
| inv_tx_i | input | 1 | Invert TX polarity |
| inv_rx_i | input | 1 | Invert RX polarity |
| timeout_i | input | TMO_W | Limit on each polled wait, in cycles |
| sel_i | input | SEL_W | Current lane-mode selector value |
| sel_o | output | SEL_W | Selector value driven by the block |
| tbl_ack_i | input | 1 | Register-table load finished |
| pll_rdy_tx_i | input | 1 | TX PLL ready (asynchronous) |
| pll_rdy_rx_i | input | 1 | RX PLL ready (asynchronous) |
| rx_init_done_i | input | 1 | RX init complete (asynchronous) |
| phy_rst_o | output | 1 | PHY reset |
| tx_idle_o | output | 1 | Hold transmitter idle |
| ivref_pu_o | output | 1 | Reference-voltage power-up |
| pll_pu_o | output | 1 | PLL power-up |
| tx_pu_o | output | 1 | TX power-up |
| rx_pu_o | output | 1 | RX power-up |
| rx_init_o | output | 1 | RX init request |
| gen_tx_o | output | 4 | TX generation code |
| gen_rx_o | output | 4 | RX generation code |
| ref_freq_o | output | 3 | Reference-frequency code |
| data_w10_o | output | 1 | 10-bit parallel data width selected |
| tx_inv_o | output | 1 | TX polarity inverted |
| rx_inv_o | output | 1 | RX polarity inverted |
| tbl_req_o | output | 1 | Request full register-table load |
| done_o | output | 1 | Sequence finished (one-cycle pulse) |
| fail_o | output | 1 | Sequence failed |

## Verification
The bench first targets the rx-init handshake with a done input that is already high when rx-init rises. A sequencer that accepted that stale level would drop rx-init at once and report success. It also changes the selector input in the middle of every run. A design that copies the live input at the end instead of the value saved at start would restore the wrong selector. The bench also checks that invalid speed codes never raise PLL power, that a 25 MHz reference never raises the table request, and that `tx_idle_o` holds while only one PLL-ready is high. Each wait is made to time out in turn, to show that a timeout still leads on to the selector restore with fail set.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RST_REL,
      S_GEN,
      S_SETTLE,
      S_CFG,
      S_TBL,
      S_PWR,
      S_PLLW,
      S_RXI,
      S_RXW,
      S_RESTORE
   } seq_state_t;

   localparam logic [3:0] GEN_1G25  = 4'h6;
   localparam logic [3:0] GEN_3G125 = 4'h8;
   localparam logic [2:0] REF_F40   = 3'd4;
   localparam logic [2:0] REF_F25   = 3'd1;

   // bit 4 = code valid, bits 3:0 = generation code
   function automatic logic [4:0] gen_lookup(input logic [1:0] spd);
      case (spd)
         2'd0:    gen_lookup = {1'b1, GEN_1G25};
         2'd1:    gen_lookup = {1'b1, GEN_3G125};
         default: gen_lookup = 5'd0;
      endcase
   endfunction

endpackage

// File: rtl/lbs_sync.sv
module lbs_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lbs_wait_timer.sv
module lbs_wait_timer #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [CW-1:0] limit,
   output logic          expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (clr)          cnt_q <= '0;
      else if (cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q >= limit);
endmodule

// File: rtl/lane_bringup_seq.sv
module lane_bringup_seq
   import lbs_pkg::*;
#(
   parameter int SEL_W       = 4,
   parameter int TMO_W       = 16,
   parameter int STAB_CYCLES = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       speed_i,
   input  logic             ref40_i,
   input  logic             inv_tx_i,
   input  logic             inv_rx_i,
   input  logic [TMO_W-1:0] timeout_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic [SEL_W-1:0] sel_o,
   input  logic             tbl_ack_i,
   input  logic             pll_rdy_tx_i,
   input  logic             pll_rdy_rx_i,
   input  logic             rx_init_done_i,
   output logic             phy_rst_o,
   output logic             tx_idle_o,
   output logic             ivref_pu_o,
   output logic             pll_pu_o,
   output logic             tx_pu_o,
   output logic             rx_pu_o,
   output logic             rx_init_o,
   output logic [3:0]       gen_tx_o,
   output logic [3:0]       gen_rx_o,
   output logic [2:0]       ref_freq_o,
   output logic             data_w10_o,
   output logic             tx_inv_o,
   output logic             rx_inv_o,
   output logic             tbl_req_o,
   output logic             done_o,
   output logic             fail_o
);
   localparam int STAB_W = $clog2(STAB_CYCLES + 1);
   localparam int CNT_W  = (TMO_W > STAB_W) ? TMO_W : STAB_W;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STAB_CYCLES < 1) begin : g_bad_stab
      $error("STAB_CYCLES must be at least 1");
   end

   seq_state_t       state_q;
   logic [SEL_W-1:0] saved_q;
   logic [1:0]       spd_q;
   logic             r40_q, itx_q, irx_q;
   logic             seen_low_q;

   logic [2:0]       syn;
   logic             rdy_tx_s, rdy_rx_s, rxdone_s;
   logic             waiting, expired;
   logic [CNT_W-1:0] limit;
   logic [4:0]       gen_l;

   lbs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pll_rdy_tx_i, pll_rdy_rx_i, rx_init_done_i}),
      .q     (syn)
   );
   assign {rdy_tx_s, rdy_rx_s, rxdone_s} = syn;

   assign waiting = (state_q == S_SETTLE) || (state_q == S_TBL) ||
                    (state_q == S_PLLW)   || (state_q == S_RXW);
   assign limit   = (state_q == S_SETTLE) ? CNT_W'(STAB_CYCLES)
                                          : CNT_W'(timeout_i);

   lbs_wait_timer #(.CW(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!waiting),
      .limit   (limit),
      .expired (expired)
   );

   assign gen_l     = gen_lookup(spd_q);
   assign tbl_req_o = (state_q == S_TBL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         saved_q    <= '0;
         sel_o      <= '0;
         spd_q      <= '0;
         r40_q      <= 1'b0;
         itx_q      <= 1'b0;
         irx_q      <= 1'b0;
         seen_low_q <= 1'b0;
         phy_rst_o  <= 1'b0;
         tx_idle_o  <= 1'b0;
         ivref_pu_o <= 1'b0;
         pll_pu_o   <= 1'b0;
         tx_pu_o    <= 1'b0;
         rx_pu_o    <= 1'b0;
         rx_init_o  <= 1'b0;
         gen_tx_o   <= '0;
         gen_rx_o   <= '0;
         ref_freq_o <= '0;
         data_w10_o <= 1'b0;
         tx_inv_o   <= 1'b0;
         rx_inv_o   <= 1'b0;
         done_o     <= 1'b0;
         fail_o     <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            S_IDLE: if (start_i) begin
               saved_q    <= sel_i;
               sel_o      <= '0;
               spd_q      <= speed_i;
               r40_q      <= ref40_i;
               itx_q      <= inv_tx_i;
               irx_q      <= inv_rx_i;
               phy_rst_o  <= 1'b1;
               tx_idle_o  <= 1'b1;
               ivref_pu_o <= 1'b1;
               pll_pu_o   <= 1'b0;
               tx_pu_o    <= 1'b0;
               rx_pu_o    <= 1'b0;
               rx_init_o  <= 1'b0;
               gen_tx_o   <= '0;
               gen_rx_o   <= '0;
               ref_freq_o <= '0;
               data_w10_o <= 1'b0;
               tx_inv_o   <= 1'b0;
               rx_inv_o   <= 1'b0;
               fail_o     <= 1'b0;
               state_q    <= S_RST_REL;
            end
            S_RST_REL: begin
               phy_rst_o <= 1'b0;
               state_q   <= S_GEN;
            end
            S_GEN: begin
               if (gen_l[4]) begin
                  gen_tx_o <= gen_l[3:0];
                  gen_rx_o <= gen_l[3:0];
                  state_q  <= S_SETTLE;
               end else begin
                  fail_o   <= 1'b1;
                  state_q  <= S_RESTORE;
               end
            end
            S_SETTLE: if (expired) state_q <= S_CFG;
            S_CFG: begin
               ref_freq_o <= r40_q ? REF_F40 : REF_F25;
               data_w10_o <= 1'b1;
               tx_inv_o   <= itx_q;
               rx_inv_o   <= irx_q;
               state_q    <= r40_q ? S_TBL : S_PWR;
            end
            S_TBL: begin
               if (tbl_ack_i) begin
                  state_q <= S_PWR;
               end else if (expired) begin
                  fail_o  <= 1'b1;
                  state_q <= S_PWR;
               end
            end
            S_PWR: begin
               pll_pu_o <= 1'b1;
               tx_pu_o  <= 1'b1;
               rx_pu_o  <= 1'b1;
               state_q  <= S_PLLW;
            end
            S_PLLW: begin
               if (rdy_tx_s && rdy_rx_s) begin
                  tx_idle_o <= 1'b0;
                  state_q   <= S_RXI;
               end else if (expired) begin
                  fail_o    <= 1'b1;
                  tx_idle_o <= 1'b0;
                  state_q   <= S_RXI;
               end
            end
            S_RXI: begin
               rx_init_o  <= 1'b1;
               seen_low_q <= 1'b0;
               state_q    <= S_RXW;
            end
            S_RXW: begin
               if (!rxdone_s) seen_low_q <= 1'b1;
               if (seen_low_q && rxdone_s) begin
                  rx_init_o <= 1'b0;
                  state_q   <= S_RESTORE;
               end else if (expired) begin
                  rx_init_o <= 1'b0;
                  fail_o    <= 1'b1;
                  state_q   <= S_RESTORE;
               end
            end
            S_RESTORE: begin
               sel_o   <= saved_q;
               done_o  <= 1'b1;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
   parameter int SEL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             phy_rst_o,
   input logic             tx_idle_o,
   input logic             ivref_pu_o,
   input logic             pll_pu_o,
   input logic             tx_pu_o,
   input logic             rx_pu_o,
   input logic             rx_init_o,
   input logic             tbl_req_o,
   input logic             data_w10_o,
   input logic [SEL_W-1:0] sel_o,
   input logic             done_o
);
   assert_reset_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      phy_rst_o |-> (tx_idle_o && ivref_pu_o && !pll_pu_o && !tx_pu_o && !rx_pu_o));

   assert_sel_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_rst_o || rx_init_o) |-> (sel_o == '0));

   assert_cfg_before_pll_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_pu_o) |-> (data_w10_o && !tbl_req_o && tx_pu_o && rx_pu_o));

   assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_idle_o) |-> (pll_pu_o && tx_pu_o && rx_pu_o));

   assert_rxinit_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_init_o |-> (!tx_idle_o && pll_pu_o));

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

bind lane_bringup_seq lbs_checker #(.SEL_W(SEL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .phy_rst_o  (phy_rst_o),
   .tx_idle_o  (tx_idle_o),
   .ivref_pu_o (ivref_pu_o),
   .pll_pu_o   (pll_pu_o),
   .tx_pu_o    (tx_pu_o),
   .rx_pu_o    (rx_pu_o),
   .rx_init_o  (rx_init_o),
   .tbl_req_o  (tbl_req_o),
   .data_w10_o (data_w10_o),
   .sel_o      (sel_o),
   .done_o     (done_o)
);

// File: tb/lane_bringup_seq_tb.sv
module lane_bringup_seq_tb;
   localparam int SEL_W = 4;
   localparam int TMO_W = 16;
   localparam int STAB  = 16;
   localparam int TMO   = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic             start_i = 1'b0;
   logic [1:0]       speed_i = '0;
   logic             ref40_i = 1'b0, inv_tx_i = 1'b0, inv_rx_i = 1'b0;
   logic [TMO_W-1:0] timeout_i = TMO_W'(TMO);
   logic [SEL_W-1:0] sel_i = '0, sel_o;
   logic             tbl_ack_i = 1'b0, pll_rdy_tx_i = 1'b0, pll_rdy_rx_i = 1'b0;
   logic             rx_init_done_i = 1'b1;
   logic phy_rst_o, tx_idle_o, ivref_pu_o, pll_pu_o, tx_pu_o, rx_pu_o, rx_init_o;
   logic [3:0] gen_tx_o, gen_rx_o;
   logic [2:0] ref_freq_o;
   logic data_w10_o, tx_inv_o, rx_inv_o, tbl_req_o, done_o, fail_o;

   lane_bringup_seq #(.SEL_W(SEL_W), .TMO_W(TMO_W), .STAB_CYCLES(STAB)) u_dut (.*);

   int errors = 0, checks = 0;

   task automatic chk(input logic ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   typedef struct {
      logic       fail;
      logic [3:0] sel, gen;
      logic [2:0] rf;
      logic       itx, irx, tbl, pll_ok, rx_ok, bad;
   } exp_t;
   exp_t q[$];

   // PHY and loader model, driven away from the active edge
   logic en_ack = 1, en_ptx = 1, en_prx = 1, rx_stuck = 0;
   int pcnt = 0, acnt = 0, rcnt = 0;
   logic m_prxi = 0;
   always @(negedge clk) begin
      if (!pll_pu_o) begin pcnt = 0; pll_rdy_tx_i = 0; pll_rdy_rx_i = 0; end
      else begin
         pcnt++;
         pll_rdy_tx_i = en_ptx && pcnt >= 5;
         pll_rdy_rx_i = en_prx && pcnt >= 5;
      end
      if (!tbl_req_o) begin acnt = 0; tbl_ack_i = 0; end
      else begin acnt++; tbl_ack_i = en_ack && acnt >= 3; end
      if (rx_init_o && !m_prxi) begin rx_init_done_i = rx_stuck; rcnt = 0; end
      else if (rx_init_o) begin rcnt++; if (rcnt >= 6) rx_init_done_i = 1; end
      m_prxi = rx_init_o;
   end

   // scoreboard monitor
   int cyc = 0, done_n = 0, t_gen = 0, t_pll = 0, t_rxi = 0;
   logic p_gen0 = 1, p_w10 = 0, p_pll = 0, p_tid = 0, p_rxi = 0, p_rst = 0, p_done = 0;
   logic tbl_seen = 0, pll_seen = 0;
   exp_t cur;
   always @(negedge clk) begin
      if (rst_n) begin
         if (q.size() > 0) cur = q[0];
         if (phy_rst_o && !p_rst)
            chk(tx_idle_o && ivref_pu_o && !pll_pu_o, "R3", "reset step pins", tx_idle_o, 1);
         if (!phy_rst_o && p_rst)
            chk(tx_idle_o == 1, "R3", "tx_idle after reset release", tx_idle_o, 1);
         if (gen_tx_o != 0 && p_gen0) begin
            t_gen = cyc;
            chk(gen_tx_o == cur.gen && gen_rx_o == cur.gen, "R4", "gen code", gen_tx_o, cur.gen);
         end
         if (data_w10_o && !p_w10) begin
            chk(cyc - t_gen >= STAB, "R5", "settle cycles", cyc - t_gen, STAB);
            chk(ref_freq_o == cur.rf, "R6", "ref_freq", ref_freq_o, cur.rf);
            chk(tx_inv_o == cur.itx && rx_inv_o == cur.irx, "R8", "polarity",
                {tx_inv_o, rx_inv_o}, {cur.itx, cur.irx});
         end
         if (tbl_req_o) tbl_seen = 1;
         if (pll_pu_o && !p_pll) begin
            t_pll = cyc; pll_seen = 1;
            chk(tx_pu_o && rx_pu_o && data_w10_o && !tbl_req_o && sel_o == 0,
                "R9", "power-up together after config", {tx_pu_o, rx_pu_o, data_w10_o}, 7);
         end
         if (!tx_idle_o && p_tid) begin
            if (cur.pll_ok)
               chk(pll_rdy_tx_i && pll_rdy_rx_i, "R9", "tx_idle drop with ready",
                   {pll_rdy_tx_i, pll_rdy_rx_i}, 3);
            else
               chk(cyc - t_pll >= TMO, "R11", "pll wait timeout length", cyc - t_pll, TMO);
         end
         if (rx_init_o && !p_rxi) t_rxi = cyc;
         if (!rx_init_o && p_rxi) begin
            if (cur.rx_ok)
               chk(rx_init_done_i && cyc - t_rxi >= 6, "R10", "rx_init hold", cyc - t_rxi, 6);
            else
               chk(cyc - t_rxi >= TMO, "R10", "stale done not accepted", cyc - t_rxi, TMO);
         end
         if (p_done)
            chk(!done_o, "R12", "done width", done_o, 0);
         if (done_o) begin
            chk(fail_o == cur.fail, "R11", "fail flag", fail_o, cur.fail);
            chk(sel_o == cur.sel, "R2", "selector restore", sel_o, cur.sel);
            chk(tbl_seen == cur.tbl, "R7", "table request", tbl_seen, cur.tbl);
            chk(pll_seen == !cur.bad, "R4", "power-up on speed code", pll_seen, !cur.bad);
            void'(q.pop_front());
            done_n++; tbl_seen = 0; pll_seen = 0;
         end
         p_gen0 = (gen_tx_o == 0);
         p_w10 = data_w10_o; p_pll = pll_pu_o; p_tid = tx_idle_o;
         p_rxi = rx_init_o; p_rst = phy_rst_o; p_done = done_o;
      end
      cyc++;
   end

   task automatic run(input logic [1:0] spd, input logic r40, input logic itx, input logic irx,
                      input logic [3:0] sel, input logic ack, input logic ptx, input logic prx,
                      input logic stuck);
      exp_t e;
      int n0;
      e.bad = (spd > 1);
      e.gen = (spd == 0) ? 4'h6 : 4'h8;
      e.rf = r40 ? 3'd4 : 3'd1;
      e.itx = itx; e.irx = irx; e.sel = sel;
      e.tbl = r40 && !e.bad;
      e.pll_ok = ptx && prx;
      e.rx_ok = !stuck;
      e.fail = e.bad || (r40 && !ack) || !e.pll_ok || stuck;
      q.push_back(e);
      en_ack = ack; en_ptx = ptx; en_prx = prx; rx_stuck = stuck;
      @(negedge clk);
      speed_i = spd; ref40_i = r40; inv_tx_i = itx; inv_rx_i = irx; sel_i = sel;
      start_i = 1;
      @(negedge clk);
      start_i = 0;
      n0 = done_n;
      repeat (5) @(negedge clk);
      sel_i = ~sel;
      while (done_n == n0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(fail_o == e.fail && !done_o, "R12", "fail held after done", fail_o, e.fail);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!phy_rst_o && !tx_idle_o && !ivref_pu_o && !pll_pu_o && !rx_init_o &&
          !tbl_req_o && !done_o && !fail_o && sel_o == 0, "R1", "reset state", 1, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(sel_o == 0 && !done_o && !data_w10_o && gen_tx_o == 0, "R1", "idle after reset", sel_o, 0);
      run(2'd0, 0, 0, 0, 4'h5, 1, 1, 1, 0);  // 1.25G, 25 MHz, clean
      run(2'd1, 1, 1, 0, 4'h3, 1, 1, 1, 0);  // 3.125G, 40 MHz, table, TX invert
      run(2'd1, 1, 0, 1, 4'h9, 0, 1, 1, 0);  // loader never acks
      run(2'd2, 1, 1, 1, 4'hA, 1, 1, 1, 0);  // invalid speed
      run(2'd3, 0, 0, 0, 4'h6, 1, 1, 1, 0);  // invalid speed
      run(2'd0, 0, 0, 0, 4'h2, 1, 1, 0, 0);  // RX PLL never ready
      run(2'd0, 1, 1, 1, 4'hC, 1, 1, 1, 1);  // rx-init done stuck high
      run(2'd1, 0, 1, 1, 4'h7, 1, 1, 1, 0);  // both inverts, 25 MHz
      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule